// File: doc/BRIEF.md
# Aliased-Window Atomic Word Memory

This block is an on-chip word store reached by one requester over a simple request/response bus. It maps the same storage four times. The two address bits just above the window offset pick one of the four copies, and the copy that is addressed decides how the word changes. Window 0 reads, writes or swaps the word. Window 1 ORs a mask into it. Window 2 clears the mask bits. Window 3 adds a value to it. Each access is a single read-modify-write that no other access can split.

A requester sets `req_ret_old` to get the word's value from before the change. This turns the set, clear and add windows into test-and-set, test-and-clear and fetch-and-add, and it turns a window-0 write into a swap. The unit accepts one request in every cycle. Its latency is a fixed two cycles. A synchronous-read array holds the words, and a one-entry forwarding register covers a request that hits the word written by the request just ahead of it.

Top module: `alias_atomic_mem`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is 0. Every word reads as zero until it is first written.
- R2: `req_addr[27:26]` selects the operation: 0 is read/write/swap, 1 is bit set, 2 is bit clear, 3 is add. All four windows reach the same words.
- R3: The word index is `req_addr[9:2]` with the default 256 words. Byte-lane bits [1:0] and offset bits [25:10] are ignored, so those addresses alias onto the same word.
- R4: In window 0, `req_wr`=0 is a read that returns the word and leaves it unchanged; `req_data` and `req_ret_old` are ignored. `req_wr`=1 with `req_ret_old`=0 stores `req_data` and gives no response. `req_wr`=1 with `req_ret_old`=1 is a swap: it stores `req_data` and returns the old word.
- R5: Window 1 stores old OR `req_data`.
- R6: Window 2 stores old AND NOT `req_data`.
- R7: Window 3 stores old plus `req_data`, modulo 2^32, with no overflow indication.
- R8: In windows 1 to 3, `req_ret_old`=1 gives a response that carries the word as it was before the change. `req_ret_old`=0 gives no response.
- R9: A request accepted at clock edge k produces its `rsp_valid`/`rsp_data` after edge k+1. A new request may be accepted on every edge.
- R10: A request to the same word as the request accepted on the edge before sees that request's result. Forwarding handles this, so back-to-back operations compose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 28 | Byte address; bits [27:26] select the window |
| req_wr | input | 1 | Window 0 only: 1 writes/swaps, 0 reads |
| req_ret_old | input | 1 | Return the pre-modification word |
| req_data | input | 32 | Write data, mask or addend |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Word before the operation (zero when no response) |

## Verification
A request presented before edge k is answered by registers loaded at edge k+1. The bench drives inputs at a falling edge and samples the response at the second falling edge after that. In single-request checks it drops `req_valid` after one cycle. The pipelined sequence issues set, add and read to one word on three consecutive edges and expects their responses on three consecutive falling edges. This shows that the second and third operations saw the forwarded result of the one before. Rows that expect no response are sampled in the same slot, so a response that arrives one cycle late or early is caught.

// File: rtl/aam_pkg.sv
package aam_pkg;
   localparam int WORD_W = 32;

   // Window encodings: the two bits above the window offset
   typedef enum logic [1:0] {
      OP_RWS  = 2'd0,
      OP_BSET = 2'd1,
      OP_BCLR = 2'd2,
      OP_ADD  = 2'd3
   } aam_op_e;
endpackage

// File: rtl/aam_win_decode.sv
module aam_win_decode
   import aam_pkg::*;
#(
   parameter int ADDR_W  = 28,
   parameter int WIN_LSB = 26,
   parameter int IDX_W   = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output aam_op_e           op,
   output logic [IDX_W-1:0]  idx
);
   localparam int GAP_LO = IDX_W + 2;

   generate
      if (ADDR_W != WIN_LSB + 2) begin : g_bad_addr
         $error("window field must be the top two address bits");
      end
      if (GAP_LO >= WIN_LSB) begin : g_bad_gap
         $error("word index overlaps window field");
      end
   endgenerate

   assign op  = aam_op_e'(addr[WIN_LSB+1:WIN_LSB]);
   assign idx = addr[IDX_W+1:2];

   // R3: byte lanes and offset bits above the index alias onto the same word
   logic addr_unused;
   assign addr_unused = ^{addr[1:0], addr[WIN_LSB-1:GAP_LO]};
endmodule

// File: rtl/aam_modify.sv
module aam_modify
   import aam_pkg::*;
(
   input  aam_op_e           op,
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] operand,
   output logic [WORD_W-1:0] new_word
);
   always_comb begin
      unique case (op)
         OP_RWS:  new_word = operand;
         OP_BSET: new_word = old_word | operand;
         OP_BCLR: new_word = old_word & ~operand;
         OP_ADD:  new_word = old_word + operand;
         default: new_word = old_word;
      endcase
   end
endmodule

// File: rtl/aam_word_ram.sv
module aam_word_ram #(
   parameter int DEPTH     = 256,
   parameter int WIDTH     = 32,
   parameter bit ZERO_INIT = 1'b1,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   generate
      if (ZERO_INIT) begin : g_cleared
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[wr_idx] <= wr_data;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[wr_idx] <= wr_data;
         end
      end
   endgenerate

   // Read-before-write: same-edge collisions are resolved by the caller
   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_idx];
   end
endmodule

// File: rtl/alias_atomic_mem.sv
module alias_atomic_mem
   import aam_pkg::*;
#(
   parameter int ADDR_W    = 28,
   parameter int WIN_LSB   = 26,
   parameter int DEPTH     = 256,
   parameter bit ZERO_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic              req_ret_old,
   input  logic [31:0]       req_data,
   output logic              rsp_valid,
   output logic [31:0]       rsp_data
);
   localparam int IDX_W   = $clog2(DEPTH);
   localparam int MAX_B   = 128 * 1024;

   generate
      if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DEPTH * 4 > MAX_B) begin : g_bad_size
         $error("storage exceeds 128 kB");
      end
   endgenerate

   // Address decode of the incoming request
   aam_op_e          req_op;
   logic [IDX_W-1:0] req_idx;

   aam_win_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .IDX_W(IDX_W)) u_dec (
      .addr (req_addr),
      .op   (req_op),
      .idx  (req_idx)
   );

   // Stage 1: request held while the array read completes
   logic              s1_valid;
   aam_op_e           s1_op;
   logic [IDX_W-1:0]  s1_idx;
   logic              s1_wr;
   logic              s1_ret;
   logic [WORD_W-1:0] s1_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= OP_RWS;
         s1_idx   <= '0;
         s1_wr    <= 1'b0;
         s1_ret   <= 1'b0;
         s1_data  <= '0;
      end else begin
         s1_valid <= req_valid;
         s1_op    <= req_op;
         s1_idx   <= req_idx;
         s1_wr    <= req_wr;
         s1_ret   <= req_ret_old;
         s1_data  <= req_data;
      end
   end

   logic s1_is_read, s1_writes, s1_answers;
   assign s1_is_read = (s1_op == OP_RWS) && !s1_wr;
   assign s1_writes  = s1_valid && !s1_is_read;
   assign s1_answers = s1_valid && (s1_is_read || s1_ret);

   // Storage and forwarding
   logic [WORD_W-1:0] ram_rd, old_word, new_word, fwd_q;
   logic              fwd_hit_q;

   aam_word_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W), .ZERO_INIT(ZERO_INIT)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (req_valid),
      .rd_idx  (req_idx),
      .rd_data (ram_rd),
      .we      (s1_writes),
      .wr_idx  (s1_idx),
      .wr_data (new_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_hit_q <= 1'b0;
         fwd_q     <= '0;
      end else begin
         fwd_hit_q <= req_valid && s1_writes && (s1_idx == req_idx);
         fwd_q     <= new_word;
      end
   end

   assign old_word = fwd_hit_q ? fwd_q : ram_rd;

   aam_modify u_mod (
      .op       (s1_op),
      .old_word (old_word),
      .operand  (s1_data),
      .new_word (new_word)
   );

   // Stage 2: response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= s1_answers;
         rsp_data  <= s1_answers ? old_word : '0;
      end
   end

   // Assertions
   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(s1_valid)); // R9

   AST_PLAIN_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s1_valid && s1_op == OP_RWS && s1_wr && !s1_ret) |-> !rsp_valid); // R4

   AST_SET_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_writes && s1_op == OP_BSET) |-> ((new_word & s1_data) == s1_data)); // R5

   AST_CLR_BITS_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_writes && s1_op == OP_BCLR) |-> ((new_word & s1_data) == '0)); // R6

   AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_writes && s1_op == OP_ADD) |-> ((new_word - s1_data) == old_word)); // R7

   AST_FWD_SEES_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && $past(s1_writes) && (s1_idx == $past(s1_idx)))
         |-> (old_word == $past(new_word))); // R10
endmodule

// File: tb/alias_atomic_mem_bench.sv
`timescale 1ns/100ps
module alias_atomic_mem_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [27:0] req_addr;
   logic        req_wr;
   logic        req_ret_old;
   logic [31:0] req_data;
   logic        rsp_valid;
   logic [31:0] rsp_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   alias_atomic_mem u_alias_atomic_mem (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_wr      (req_wr),
      .req_ret_old (req_ret_old),
      .req_data    (req_data),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data)
   );

   typedef struct packed {
      logic [27:0] addr;
      logic        wr;
      logic        ret;
      logic [31:0] data;
      logic        ev;
      logic [31:0] ed;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{28'h000000C, 1'b1, 1'b0, 32'hA5A5_0F0F, 1'b0, 32'h0,         8'd4},  // R4 write
      '{28'h000000C, 1'b0, 1'b0, 32'h0,         1'b1, 32'hA5A5_0F0F, 8'd4},  // R4 read
      '{28'h400000C, 1'b0, 1'b1, 32'h0000_F0F0, 1'b1, 32'hA5A5_0F0F, 8'd5},  // R5 test-and-set
      '{28'h000000C, 1'b0, 1'b0, 32'h0,         1'b1, 32'hA5A5_FFFF, 8'd5},  // R5 result
      '{28'h800000C, 1'b0, 1'b0, 32'hFF00_00FF, 1'b0, 32'h0,         8'd8},  // R8 silent clear
      '{28'h000000C, 1'b0, 1'b1, 32'h0000_DEAD, 1'b1, 32'h00A5_FF00, 8'd6},  // R6 result, read ignores data
      '{28'hC00000C, 1'b0, 1'b1, 32'h0001_0100, 1'b1, 32'h00A5_FF00, 8'd7},  // R7 fetch-and-add
      '{28'h000000C, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h00A7_0000, 8'd4},  // R4 swap
      '{28'hC00000C, 1'b0, 1'b1, 32'h0000_0002, 1'b1, 32'hFFFF_FFFF, 8'd7},  // R7 add wraps
      '{28'h000000C, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_0001, 8'd7},  // R7 wrapped sum
      '{28'h0000010, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_0000, 8'd1},  // R1 untouched word
      '{28'h4000010, 1'b0, 1'b0, 32'h0000_0008, 1'b0, 32'h0,         8'd8},  // R8 silent set
      '{28'h0000010, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_0008, 8'd2},  // R2 windows share word
      '{28'h010001E, 1'b1, 1'b0, 32'h1234_5678, 1'b0, 32'h0,         8'd3},  // R3 aliased write
      '{28'h000001C, 1'b0, 1'b0, 32'h0,         1'b1, 32'h1234_5678, 8'd3},  // R3 read via plain addr
      '{28'h800001C, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h1234_5678, 8'd6}   // R6 zero mask keeps word
   };

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic drive(input logic [27:0] a, input logic w, input logic r, input logic [31:0] d);
      req_valid   = 1'b1;
      req_addr    = a;
      req_wr      = w;
      req_ret_old = r;
      req_data    = d;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      req_wr    = 1'b0;
      req_data  = '0;
   endtask

   // One request from a falling edge; response sampled two falling edges later
   task automatic one_req(input logic [27:0] a, input logic w, input logic r, input logic [31:0] d,
                          input logic ev, input logic [31:0] ed, input string rq);
      drive(a, w, r, d);
      @(negedge clk);
      idle();
      @(negedge clk);
      chk(rsp_valid == ev, rq, {31'b0, rsp_valid}, {31'b0, ev});
      if (ev) chk(rsp_data == ed, rq, rsp_data, ed);
   endtask

   initial begin
      rst_n = 1'b0;
      idle();
      req_addr = '0;
      req_ret_old = 1'b0;
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", {31'b0, rsp_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", {31'b0, rsp_valid}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         one_req(TBL[i].addr, TBL[i].wr, TBL[i].ret, TBL[i].data, TBL[i].ev, TBL[i].ed,
                 $sformatf("R%0d", TBL[i].rq));
      end

      // R10: back-to-back set, add, read on word 5 (start 0x10)
      one_req(28'h0000014, 1'b1, 1'b0, 32'h0000_0010, 1'b0, 32'h0, "R10");
      drive(28'h4000014, 1'b0, 1'b1, 32'h0000_0001);
      @(negedge clk);
      drive(28'hC000014, 1'b0, 1'b1, 32'h0000_0100);
      @(negedge clk);
      drive(28'h0000014, 1'b0, 1'b0, 32'h0);
      chk(rsp_valid && rsp_data == 32'h10, "R9", rsp_data, 32'h10);
      @(negedge clk);
      idle();
      chk(rsp_valid && rsp_data == 32'h11, "R10", rsp_data, 32'h11);
      @(negedge clk);
      chk(rsp_valid && rsp_data == 32'h111, "R10", rsp_data, 32'h111);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9", {31'b0, rsp_valid}, 32'h0);

      // R10: back-to-back adds across windows on two different words
      drive(28'hC000014, 1'b0, 1'b1, 32'h0000_0001);
      @(negedge clk);
      drive(28'hC000018, 1'b0, 1'b1, 32'h0000_0005);
      @(negedge clk);
      drive(28'hC000014, 1'b0, 1'b1, 32'h0000_0001);
      chk(rsp_data == 32'h111, "R10", rsp_data, 32'h111);
      @(negedge clk);
      idle();
      chk(rsp_data == 32'h0, "R10", rsp_data, 32'h0);
      @(negedge clk);
      chk(rsp_data == 32'h112, "R10", rsp_data, 32'h112);

      // R1: reset again clears the response
      drive(28'h0000014, 1'b0, 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b0;
      idle();
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", {31'b0, rsp_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      one_req(28'h0000014, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0, "R1");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule